// File: doc/BRIEF.md
# Banked Bidirectional Bus Multiplexing Latch

This block joins one narrow data port, A, to two banked ports of the same width, called bank 1 and bank 2. In the A-to-bank direction, the value on A can be stored into either bank's outbound store. Each store has its own load enable, so one A transfer can land in bank 1, bank 2, or both. In the bank-to-A direction, each bank's input is held in its own inbound store. A select input then picks which of the two inbound stores appears on A. This lets two separate datapaths share one narrow path, for example address and data words on a time-shared bus, or two interleaved memory banks.

Every port would be a three-state pin in a real design. Here each pin is split into an input bus, an output bus and a drive flag. Each port has its own active-low output enable. The drive flag is high exactly when that enable is low. A released port also forces its output bus to zero.

The stores are enable-gated registers by default. A package parameter value selects level-sensitive latches instead. A synchronous active-high reset clears all four stores.

Top module: `mux_bus_latch`

## Requirements
- R1: A clock edge with `rst` high clears all four stores to zero. After reset, with every output enable low, `a_out`, `b1_out` and `b2_out` all read zero.
- R2: At a rising edge with `ld_ab1` high, the bank 1 outbound store takes `a_in`. The new value is visible on `b1_out` right after that edge.
- R3: At a rising edge with `ld_ab2` high, the bank 2 outbound store takes `a_in`. Loading one outbound bank never alters the other one.
- R4: While a store's load enable is low, the store keeps its value across any number of edges, whatever its data input does.
- R5: At a rising edge, `ld_b1a` high loads `b1_in` into the bank 1 inbound store, and `ld_b2a` high loads `b2_in` into the bank 2 inbound store.
- R6: `sel_b1` = 1 shows the bank 1 inbound store on `a_out`, and `sel_b1` = 0 shows the bank 2 inbound store. The choice takes effect with no clock edge.
- R7: Each drive flag is the inverse of its active-low output enable. While a port's enable is high, its drive flag is 0 and its output bus reads zero. Both follow the enable with no clock edge.
- R8: The three output enables act independently. Releasing one port leaves the other ports' outputs and drive flags unchanged.
- R9: The outbound stores (A to banks) and the inbound stores (banks to A) are separate. Loading one direction never changes what the other direction shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears all stores |
| a_in | input | W | Value arriving on port A |
| a_out | output | W | Value driven onto port A (zero when released) |
| a_drive | output | 1 | High while port A is driven |
| b1_in | input | W | Value arriving on bank 1 |
| b1_out | output | W | Value driven onto bank 1 (zero when released) |
| b1_drive | output | 1 | High while bank 1 is driven |
| b2_in | input | W | Value arriving on bank 2 |
| b2_out | output | W | Value driven onto bank 2 (zero when released) |
| b2_drive | output | 1 | High while bank 2 is driven |
| sel_b1 | input | 1 | 1 shows bank 1 inbound store on A, 0 shows bank 2 |
| ld_ab1 | input | 1 | Load enable, A into bank 1 outbound store |
| ld_ab2 | input | 1 | Load enable, A into bank 2 outbound store |
| ld_b1a | input | 1 | Load enable, bank 1 into its inbound store |
| ld_b2a | input | 1 | Load enable, bank 2 into its inbound store |
| oe_a_n | input | 1 | Active-low output enable for port A |
| oe_b1_n | input | 1 | Active-low output enable for bank 1 |
| oe_b2_n | input | 1 | Active-low output enable for bank 2 |

## Verification
The properties assume the register variant of the stores. They also assume that every input changes only between rising edges, so that the value of a load enable and its data sampled at one edge decide that store's content after the edge. The load and hold properties only make a claim when the port concerned is driven in the following cycle, because a released port reads zero. The stimulus applies every input one nanosecond after a rising edge and holds it until the next edge.

// File: rtl/mux_bus_latch_pkg.sv
package mux_bus_latch_pkg;
  typedef enum logic {
    HOLD_REG   = 1'b0,
    HOLD_LATCH = 1'b1
  } hold_e;
  localparam int unsigned DEF_W = 12;
  localparam int unsigned N_BANK = 2;
endpackage

// File: rtl/bank_store.sv
module bank_store
  import mux_bus_latch_pkg::*;
#(
  parameter int unsigned W    = DEF_W,
  parameter hold_e       HOLD = HOLD_REG
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (HOLD == HOLD_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (en) q <= d;
      end
    end else begin : g_latch
      always_latch begin
        if (rst)     q = '0;
        else if (en) q = d;
      end
    end
  endgenerate
endmodule

// File: rtl/port_drive.sv
module port_drive #(
  parameter int unsigned W = 12
) (
  input  logic         oe_n,
  input  logic [W-1:0] data,
  output logic [W-1:0] out,
  output logic         drive
);
  always_comb begin
    drive = ~oe_n;
    out   = oe_n ? '0 : data;
  end
endmodule

// File: rtl/read_sel.sv
module read_sel #(
  parameter int unsigned W = 12
) (
  input  logic         sel_first,
  input  logic [W-1:0] first,
  input  logic [W-1:0] second,
  output logic [W-1:0] y
);
  always_comb y = sel_first ? first : second;
endmodule

// File: rtl/mux_bus_latch.sv
module mux_bus_latch
  import mux_bus_latch_pkg::*;
#(
  parameter int unsigned W    = DEF_W,
  parameter hold_e       HOLD = HOLD_REG
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_drive,
  input  logic [W-1:0] b1_in,
  output logic [W-1:0] b1_out,
  output logic         b1_drive,
  input  logic [W-1:0] b2_in,
  output logic [W-1:0] b2_out,
  output logic         b2_drive,
  input  logic         sel_b1,
  input  logic         ld_ab1,
  input  logic         ld_ab2,
  input  logic         ld_b1a,
  input  logic         ld_b2a,
  input  logic         oe_a_n,
  input  logic         oe_b1_n,
  input  logic         oe_b2_n
);
  // Per-bank views: index 0 is bank 1, index 1 is bank 2.
  logic [N_BANK-1:0][W-1:0] out_q;   // A-to-bank stores
  logic [N_BANK-1:0][W-1:0] in_q;    // bank-to-A stores
  logic [N_BANK-1:0][W-1:0] bank_in;
  logic [N_BANK-1:0][W-1:0] bank_out;
  logic [N_BANK-1:0]        ld_out;
  logic [N_BANK-1:0]        ld_in;
  logic [N_BANK-1:0]        bank_oe_n;
  logic [N_BANK-1:0]        bank_drv;
  logic [W-1:0]             a_pick;

  always_comb begin
    bank_in   = {b2_in, b1_in};
    ld_out    = {ld_ab2, ld_ab1};
    ld_in     = {ld_b2a, ld_b1a};
    bank_oe_n = {oe_b2_n, oe_b1_n};
  end

  genvar gi;
  generate
    for (gi = 0; gi < N_BANK; gi++) begin : g_bank
      bank_store #(.W(W), .HOLD(HOLD)) u_out_store (
        .clk (clk), .rst (rst), .en (ld_out[gi]),
        .d   (a_in), .q (out_q[gi])
      );
      bank_store #(.W(W), .HOLD(HOLD)) u_in_store (
        .clk (clk), .rst (rst), .en (ld_in[gi]),
        .d   (bank_in[gi]), .q (in_q[gi])
      );
      port_drive #(.W(W)) u_bank_drv (
        .oe_n  (bank_oe_n[gi]), .data (out_q[gi]),
        .out   (bank_out[gi]),  .drive (bank_drv[gi])
      );
    end
  endgenerate

  read_sel #(.W(W)) u_sel (
    .sel_first (sel_b1), .first (in_q[0]), .second (in_q[1]), .y (a_pick)
  );

  port_drive #(.W(W)) u_a_drv (
    .oe_n (oe_a_n), .data (a_pick), .out (a_out), .drive (a_drive)
  );

  always_comb begin
    b1_out   = bank_out[0];
    b2_out   = bank_out[1];
    b1_drive = bank_drv[0];
    b2_drive = bank_drv[1];
  end
endmodule

// File: rtl/mux_bus_latch_chk.sv
module mux_bus_latch_chk #(
  parameter int unsigned W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic         a_drive,
  input logic [W-1:0] b1_in,
  input logic [W-1:0] b1_out,
  input logic         b1_drive,
  input logic [W-1:0] b2_in,
  input logic [W-1:0] b2_out,
  input logic         b2_drive,
  input logic         sel_b1,
  input logic         ld_ab1,
  input logic         ld_ab2,
  input logic         ld_b1a,
  input logic         ld_b2a,
  input logic         oe_a_n,
  input logic         oe_b1_n,
  input logic         oe_b2_n
);
  p_reset_clear_r1: assert property (@(posedge clk)
    ($past(rst) && !oe_b1_n) |-> b1_out == '0);

  p_load_b1_r2: assert property (@(posedge clk) disable iff (rst)
    ld_ab1 |=> (oe_b1_n || b1_out == $past(a_in)));

  p_load_b2_r3: assert property (@(posedge clk) disable iff (rst)
    ld_ab2 |=> (oe_b2_n || b2_out == $past(a_in)));

  p_hold_b1_r4: assert property (@(posedge clk) disable iff (rst)
    (!ld_ab1 && !oe_b1_n) |=> (oe_b1_n || $stable(b1_out)));

  p_readback_b1_r5: assert property (@(posedge clk) disable iff (rst)
    (ld_b1a && sel_b1) |=> (!sel_b1 || oe_a_n || a_out == $past(b1_in)));

  p_readback_b2_r6: assert property (@(posedge clk) disable iff (rst)
    (ld_b2a && !sel_b1) |=> (sel_b1 || oe_a_n || a_out == $past(b2_in)));

  p_released_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (!a_drive |-> a_out == '0) and (!b1_drive |-> b1_out == '0)
    and (!b2_drive |-> b2_out == '0));

  p_drive_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    (oe_a_n && !oe_b1_n && oe_b2_n) |-> $onehot0({a_drive, b1_drive, b2_drive}) && b1_drive);
endmodule

bind mux_bus_latch mux_bus_latch_chk #(.W(W)) u_chk (.*);

// File: tb/test_mux_bus_latch.sv
`timescale 1ns/1ps
module test_mux_bus_latch;
  localparam int W = 12;
  localparam logic [W-1:0] Z = '0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
  logic [W-1:0] a_out, b1_out, b2_out;
  logic a_drive, b1_drive, b2_drive;
  logic sel_b1 = 1'b0;
  logic ld_ab1 = 1'b0, ld_ab2 = 1'b0, ld_b1a = 1'b0, ld_b2a = 1'b0;
  logic oe_a_n = 1'b1, oe_b1_n = 1'b1, oe_b2_n = 1'b1;

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0] m_ab1, m_ab2, m_ba1, m_ba2;

  always #2 clk = ~clk;

  mux_bus_latch #(.W(W)) i_mux_bus_latch (.*);

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    ld_ab1 = 0; ld_ab2 = 0; ld_b1a = 0; ld_b2a = 0;
  endtask

  task automatic check_all(input string req);
    logic [W-1:0] pick;
    pick = sel_b1 ? m_ba1 : m_ba2;
    check(req, a_out,  oe_a_n  ? Z : pick);
    check(req, b1_out, oe_b1_n ? Z : m_ab1);
    check(req, b2_out, oe_b2_n ? Z : m_ab2);
    check(req, W'(a_drive),  W'(!oe_a_n));
    check(req, W'(b1_drive), W'(!oe_b1_n));
    check(req, W'(b2_drive), W'(!oe_b2_n));
  endtask

  task automatic t_reset();
    rst = 1; idle();
    a_in = 12'hFFF; b1_in = 12'hFFF; b2_in = 12'hFFF;
    step(); step();
    // R7: all enables high -> all released
    check("R7 released at power-up", {a_drive, b1_drive, b2_drive}, Z);
    rst = 0; oe_a_n = 0; oe_b1_n = 0; oe_b2_n = 0;
    m_ab1 = '0; m_ab2 = '0; m_ba1 = '0; m_ba2 = '0;
    step();
    sel_b1 = 1; #1 check("R1 a_out sel1", a_out, Z);
    sel_b1 = 0; #1 check("R1 a_out sel0", a_out, Z);
    check("R1 b1_out", b1_out, Z);
    check("R1 b2_out", b2_out, Z);
  endtask

  task automatic t_load_ab();
    a_in = 12'h5A3; ld_ab1 = 1; step(); idle(); m_ab1 = 12'h5A3;
    check("R2 b1 load", b1_out, 12'h5A3);
    check("R3 b2 untouched", b2_out, m_ab2);
    a_in = 12'h0C7; ld_ab2 = 1; step(); idle(); m_ab2 = 12'h0C7;
    check("R3 b2 load", b2_out, 12'h0C7);
    check("R3 b1 untouched", b1_out, 12'h5A3);
    check("R9 a_out unaffected", a_out, m_ba2);
  endtask

  task automatic t_hold();
    for (int i = 0; i < 5; i++) begin
      a_in = 12'(i * 12'h333 + 1); b1_in = ~a_in; b2_in = a_in ^ 12'hAAA;
      step();
      check("R4 b1 hold", b1_out, m_ab1);
      check("R4 b2 hold", b2_out, m_ab2);
      check("R4 a hold", a_out, m_ba2);
    end
  endtask

  task automatic t_readback();
    b1_in = 12'h123; b2_in = 12'hFED; ld_b1a = 1; ld_b2a = 1;
    step(); idle(); m_ba1 = 12'h123; m_ba2 = 12'hFED;
    sel_b1 = 1; #1 check("R5 R6 bank1 on A", a_out, 12'h123);
    sel_b1 = 0; #1 check("R5 R6 bank2 on A", a_out, 12'hFED);
    check("R9 b1 unaffected", b1_out, m_ab1);
    check("R9 b2 unaffected", b2_out, m_ab2);
    b1_in = 12'h777; ld_b1a = 1; step(); idle(); m_ba1 = 12'h777;
    check("R5 only bank1 inbound changed", a_out, 12'hFED);
    sel_b1 = 1; #1 check("R6 sel switch", a_out, 12'h777);
  endtask

  task automatic t_oe();
    oe_b1_n = 1; #1;
    check("R7 b1 released out", b1_out, Z);
    check("R7 b1 drive", W'(b1_drive), Z);
    check("R8 b2 still driven", b2_out, m_ab2);
    check("R8 a still driven", a_out, m_ba1);
    oe_b1_n = 0; oe_a_n = 1; #1;
    check("R7 a released", a_out, Z);
    check("R8 b1 back", b1_out, m_ab1);
    oe_a_n = 0; oe_b2_n = 1; #1;
    check("R7 b2 released", b2_out, Z);
    check("R8 a back", a_out, m_ba1);
    oe_b2_n = 0; #1;
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 256; i++) begin
      logic [7:0] c;
      c = 8'(i);
      sel_b1 = c[0]; ld_ab1 = c[1]; ld_ab2 = c[2]; ld_b1a = c[3]; ld_b2a = c[4];
      oe_a_n = c[5]; oe_b1_n = c[6]; oe_b2_n = c[7];
      a_in = W'($urandom); b1_in = W'($urandom); b2_in = W'($urandom);
      step();
      if (ld_ab1) m_ab1 = a_in;
      if (ld_ab2) m_ab2 = a_in;
      if (ld_b1a) m_ba1 = b1_in;
      if (ld_b2a) m_ba2 = b2_in;
      check_all("R2 R3 R4 R5 R6 R7 R8 R9 sweep");
    end
    idle(); oe_a_n = 0; oe_b1_n = 0; oe_b2_n = 0;
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_load_ab();
    t_hold();
    t_readback();
    t_oe();
    t_sweep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule